// File: doc/BRIEF.md
# Merging Global Memory Block Controller

This controller sits in front of a small global memory shared by several processing elements. It keeps sharing state for every data block: a count of the caches that currently hold a copy, a suspend bit, and a bitmask with one bit per word that records which words have already been merged back. It does not record which elements hold a copy. Dirty copies of the same block can come back from several writers, and the controller combines them word by word. A word is taken from a writeback only if no earlier writeback has already changed it and the new value differs from memory.

Requests arrive one at a time on a request port that carries an opcode, a block address, a word index, a requester id and a full line of data. Results leave on registered response, suspend and reinitialize pulses. The suspend pulse hands a refused fetch or lock to an external wait queue. The reinitialize pulse tells that queue that a block has returned to its free state. A flush that needs merging takes one cycle per word, and `busy` holds off new requests for that time. The suspend bit also serves as a lock bit for blocks that are used for synchronisation.

Top module: `merge_block_ctrl`

## Requirements
- R1: After reset every block has count 0, suspend 0 and an empty bitmask, all memory words read 0, `busy` is low, and no output pulse is active.
- R2: A fetch (opcode 0) of a block whose suspend bit is clear increments its count. In the next cycle it raises `rsp_valid` with the block on `rsp_data` (word i at bits i*WORD_W upward) and the requester on `rsp_pe`.
- R3: A fetch of a block whose suspend bit is set returns no data. In the next cycle it raises `susp_valid` with the requester on `susp_pe` and the block on `susp_blk`.
- R4: A flush (opcode 1) of a block with count 1 and suspend 0 writes the whole incoming line in one cycle, sets the count to 0, does not raise `busy`, and pulses `reinit_valid`.
- R5: Any other flush of a block with a nonzero count raises `busy` for exactly WORDS cycles. Each word whose mask bit is 0 and whose incoming value differs from memory is written, and its mask bit is set. At the end the count is decremented and the suspend bit is set.
- R6: A clean-replacement report (opcode 2) decrements the count and produces no response.
- R7: When a decrement brings a count to zero, the block's bitmask and suspend bit are cleared, and `reinit_valid` pulses with the block on `reinit_blk`. This happens in the cycle after the last merge step, or in the cycle after a replacement report.
- R8: A bypass read (opcode 3) returns the addressed word zero-extended on `rsp_data`. A bypass write (opcode 4) stores the low word of `req_data`. Neither touches the block state.
- R9: Test-and-set (opcode 7) sets the suspend bit and returns its previous value on `rsp_flag` with `rsp_valid`.
- R10: Lock (opcode 5) on a clear suspend bit sets it and responds with `rsp_flag` 0. On a set suspend bit it raises `susp_valid` instead.
- R11: Unlock (opcode 6) clears the bitmask and the suspend bit, leaves the count unchanged, and pulses `reinit_valid` for the block.
- R12: A flush or replacement report on a block whose count is 0 pulses `proto_err` and changes neither memory nor block state.
- R13: A request presented while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | Opcode: 0 fetch, 1 flush, 2 replace, 3 bypass read, 4 bypass write, 5 lock, 6 unlock, 7 test-and-set |
| req_blk | input | BLK_W | Block address |
| req_word | input | WIDX_W | Word index for bypass accesses |
| req_pe | input | ID_W | Requester id |
| req_data | input | WORDS*WORD_W | Flushed line, or bypass write word in the low bits |
| busy | output | 1 | Merge in progress; requests are ignored |
| rsp_valid | output | 1 | Response pulse |
| rsp_flag | output | 1 | Previous suspend bit for lock and test-and-set |
| rsp_pe | output | ID_W | Requester of the response |
| rsp_data | output | WORDS*WORD_W | Block line or bypass word |
| susp_valid | output | 1 | Request handed to the wait queue |
| susp_pe | output | ID_W | Suspended requester |
| susp_blk | output | BLK_W | Block of the suspended request |
| reinit_valid | output | 1 | Block returned to free state |
| reinit_blk | output | BLK_W | Block that was reinitialized |
| proto_err | output | 1 | Decrement of a zero count was refused |

## Verification
Every cycle, the assertions check that a response and a suspend pulse never occur together, that a fetch always yields exactly one of the two, and that a bypass read always answers. They also check that an unlock reinitializes the addressed block, that a replacement stays silent, that an error never coincides with a reinitialize, and that a merge holds `busy` for exactly WORDS cycles. Only the bench scenarios can show what the merge puts into memory. That covers which words a second writer may still change, whether the full-line path is taken, and whether the count reaches zero at the right request. The bench reads these results back through fetches and bypass reads.

// File: rtl/mgc_pkg.sv
package mgc_pkg;
    typedef enum logic [2:0] {
        OP_FETCH  = 3'd0,
        OP_FLUSH  = 3'd1,
        OP_DROP   = 3'd2,
        OP_BRD    = 3'd3,
        OP_BWR    = 3'd4,
        OP_LOCK   = 3'd5,
        OP_UNLOCK = 3'd6,
        OP_TAS    = 3'd7
    } mg_op_e;
endpackage

// File: rtl/mgc_word_merge.sv
// Decides whether one incoming word may replace the stored one.
module mgc_word_merge #(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] old_w,
    input  logic [WORD_W-1:0] new_w,
    input  logic              taken,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_w
);
    always_comb begin
        wr_en = !taken && (old_w != new_w);
        wr_w  = wr_en ? new_w : old_w;
    end
endmodule

// File: rtl/mgc_cnt_step.sv
// Holder count update: increment, guarded decrement, zero detection.
module mgc_cnt_step #(
    parameter int CNT_W = 3
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             hit_zero,
    output logic             underflow
);
    always_comb begin
        underflow = dec && (cnt == '0);
        hit_zero  = dec && (cnt == CNT_W'(1));
        if (inc)
            cnt_nxt = cnt + CNT_W'(1);
        else if (dec && !underflow)
            cnt_nxt = cnt - CNT_W'(1);
        else
            cnt_nxt = cnt;
    end
endmodule

// File: rtl/merge_block_ctrl.sv
module merge_block_ctrl #(
    parameter int NUM_BLOCKS = 4,
    parameter int WORDS      = 4,
    parameter int WORD_W     = 16,
    parameter int NUM_PE     = 4,
    localparam int BLK_W     = $clog2(NUM_BLOCKS),
    localparam int WIDX_W    = $clog2(WORDS),
    localparam int ID_W      = $clog2(NUM_PE),
    localparam int LINE_W    = WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [BLK_W-1:0]  req_blk,
    input  logic [WIDX_W-1:0] req_word,
    input  logic [ID_W-1:0]   req_pe,
    input  logic [LINE_W-1:0] req_data,
    output logic              busy,
    output logic              rsp_valid,
    output logic              rsp_flag,
    output logic [ID_W-1:0]   rsp_pe,
    output logic [LINE_W-1:0] rsp_data,
    output logic              susp_valid,
    output logic [ID_W-1:0]   susp_pe,
    output logic [BLK_W-1:0]  susp_blk,
    output logic              reinit_valid,
    output logic [BLK_W-1:0]  reinit_blk,
    output logic              proto_err
);
    import mgc_pkg::*;

    // Block counts and words per block are powers of two: addresses are {blk, word}.
    localparam int CNT_W  = $clog2(NUM_PE + 1);
    localparam int ADDR_W = BLK_W + WIDX_W;
    localparam int CELLS  = NUM_BLOCKS * WORDS;

    typedef struct packed {
        logic                                merging;
        logic [WIDX_W-1:0]                   idx;
        logic [BLK_W-1:0]                    blk;
        logic [LINE_W-1:0]                   line;
        logic [NUM_BLOCKS-1:0][CNT_W-1:0]    cnt;
        logic [NUM_BLOCKS-1:0]               susp;
        logic [NUM_BLOCKS-1:0][WORDS-1:0]    mask;
        logic [CELLS-1:0][WORD_W-1:0]        mem;
        logic                                o_rsp;
        logic                                o_flag;
        logic                                o_susp;
        logic                                o_reinit;
        logic                                o_err;
        logic [ID_W-1:0]                     o_pe;
        logic [BLK_W-1:0]                    o_blk;
        logic [LINE_W-1:0]                   o_data;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    logic              accept;
    mg_op_e            op;
    logic [BLK_W-1:0]  sel_blk;
    logic              last_step;
    logic              cnt_inc, cnt_dec;
    logic [CNT_W-1:0]  cnt_nxt;
    logic              cnt_zero, cnt_uflow;
    logic [ADDR_W-1:0] m_addr;
    logic              m_we;
    logic [WORD_W-1:0] m_word;
    logic [ADDR_W-1:0] r_base;

    assign accept    = req_valid && !st_q.merging;
    assign op        = mg_op_e'(req_op);
    assign sel_blk   = st_q.merging ? st_q.blk : req_blk;
    assign last_step = st_q.merging && (st_q.idx == WIDX_W'(WORDS - 1));
    assign cnt_inc   = accept && (op == OP_FETCH) && !st_q.susp[req_blk];
    assign cnt_dec   = last_step || (accept && (op == OP_DROP));
    assign m_addr    = {st_q.blk, st_q.idx};
    assign r_base    = {req_blk, {WIDX_W{1'b0}}};

    mgc_cnt_step #(.CNT_W(CNT_W)) u_cnt (
        .cnt       (st_q.cnt[sel_blk]),
        .inc       (cnt_inc),
        .dec       (cnt_dec),
        .cnt_nxt   (cnt_nxt),
        .hit_zero  (cnt_zero),
        .underflow (cnt_uflow)
    );

    mgc_word_merge #(.WORD_W(WORD_W)) u_merge (
        .old_w (st_q.mem[m_addr]),
        .new_w (st_q.line[st_q.idx*WORD_W +: WORD_W]),
        .taken (st_q.mask[st_q.blk][st_q.idx]),
        .wr_en (m_we),
        .wr_w  (m_word)
    );

    always_comb begin
        st_d          = st_q;
        st_d.o_rsp    = 1'b0;
        st_d.o_flag   = 1'b0;
        st_d.o_susp   = 1'b0;
        st_d.o_reinit = 1'b0;
        st_d.o_err    = 1'b0;
        st_d.o_data   = '0;

        if (st_q.merging) begin
            if (m_we) begin
                st_d.mem[m_addr]                = m_word;
                st_d.mask[st_q.blk][st_q.idx]   = 1'b1;
            end
            if (last_step) begin
                st_d.merging        = 1'b0;
                st_d.cnt[st_q.blk]  = cnt_nxt;
                st_d.susp[st_q.blk] = 1'b1;
                if (cnt_zero) begin
                    st_d.mask[st_q.blk] = '0;
                    st_d.susp[st_q.blk] = 1'b0;
                    st_d.o_reinit       = 1'b1;
                    st_d.o_blk          = st_q.blk;
                end
            end else begin
                st_d.idx = st_q.idx + WIDX_W'(1);
            end
        end else if (accept) begin
            st_d.o_pe  = req_pe;
            st_d.o_blk = req_blk;
            unique case (op)
                OP_FETCH: begin
                    if (st_q.susp[req_blk]) begin
                        st_d.o_susp = 1'b1;
                    end else begin
                        st_d.cnt[req_blk] = cnt_nxt;
                        st_d.o_rsp        = 1'b1;
                        st_d.o_data       = st_q.mem[r_base +: WORDS];
                    end
                end
                OP_FLUSH: begin
                    if (st_q.cnt[req_blk] == '0) begin
                        st_d.o_err = 1'b1;
                    end else if (st_q.cnt[req_blk] == CNT_W'(1) && !st_q.susp[req_blk]) begin
                        st_d.mem[r_base +: WORDS] = req_data;
                        st_d.cnt[req_blk]         = '0;
                        st_d.mask[req_blk]        = '0;
                        st_d.o_reinit             = 1'b1;
                    end else begin
                        st_d.merging = 1'b1;
                        st_d.idx     = '0;
                        st_d.blk     = req_blk;
                        st_d.line    = req_data;
                    end
                end
                OP_DROP: begin
                    if (cnt_uflow) begin
                        st_d.o_err = 1'b1;
                    end else begin
                        st_d.cnt[req_blk] = cnt_nxt;
                        if (cnt_zero) begin
                            st_d.mask[req_blk] = '0;
                            st_d.susp[req_blk] = 1'b0;
                            st_d.o_reinit      = 1'b1;
                        end
                    end
                end
                OP_BRD: begin
                    st_d.o_rsp  = 1'b1;
                    st_d.o_data = LINE_W'(st_q.mem[{req_blk, req_word}]);
                end
                OP_BWR: begin
                    st_d.mem[{req_blk, req_word}] = req_data[WORD_W-1:0];
                end
                OP_LOCK: begin
                    if (st_q.susp[req_blk]) begin
                        st_d.o_susp = 1'b1;
                    end else begin
                        st_d.susp[req_blk] = 1'b1;
                        st_d.o_rsp         = 1'b1;
                    end
                end
                OP_UNLOCK: begin
                    st_d.mask[req_blk] = '0;
                    st_d.susp[req_blk] = 1'b0;
                    st_d.o_reinit      = 1'b1;
                end
                OP_TAS: begin
                    st_d.o_rsp         = 1'b1;
                    st_d.o_flag        = st_q.susp[req_blk];
                    st_d.susp[req_blk] = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy         = st_q.merging;
    assign rsp_valid    = st_q.o_rsp;
    assign rsp_flag     = st_q.o_flag;
    assign rsp_pe       = st_q.o_pe;
    assign rsp_data     = st_q.o_data;
    assign susp_valid   = st_q.o_susp;
    assign susp_pe      = st_q.o_pe;
    assign susp_blk     = st_q.o_blk;
    assign reinit_valid = st_q.o_reinit;
    assign reinit_blk   = st_q.o_blk;
    assign proto_err    = st_q.o_err;
endmodule

// File: rtl/mgc_checker.sv
module mgc_checker #(
    parameter int WORDS = 4,
    parameter int BLK_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [2:0]       req_op,
    input logic [BLK_W-1:0] req_blk,
    input logic             busy,
    input logic             rsp_valid,
    input logic             susp_valid,
    input logic             reinit_valid,
    input logic [BLK_W-1:0] reinit_blk,
    input logic             proto_err
);
    localparam int RUN_W = $clog2(WORDS + 1) + 1;

    logic             take;
    logic [RUN_W-1:0] run_q;

    assign take = req_valid && !busy;

    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + RUN_W'(1);
        else           run_q <= '0;
    end

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_valid, susp_valid})); // R3
    AST_FETCH_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_op == 3'd0) |=> (rsp_valid ^ susp_valid)); // R2
    AST_BYPASS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_op == 3'd3) |=> (rsp_valid && !susp_valid)); // R8
    AST_UNLOCK_REINIT: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_op == 3'd6) |=> (reinit_valid && reinit_blk == $past(req_blk))); // R11
    AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_op == 3'd2) |=> !rsp_valid); // R6
    AST_ERR_NO_REINIT: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> !reinit_valid); // R12
    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!rsp_valid && !susp_valid)); // R13
    AST_MERGE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q < RUN_W'(WORDS))); // R5
    AST_MERGE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == RUN_W'(WORDS))); // R5
endmodule

bind merge_block_ctrl mgc_checker #(.WORDS(WORDS), .BLK_W(BLK_W)) u_mgc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_op       (req_op),
    .req_blk      (req_blk),
    .busy         (busy),
    .rsp_valid    (rsp_valid),
    .susp_valid   (susp_valid),
    .reinit_valid (reinit_valid),
    .reinit_blk   (reinit_blk),
    .proto_err    (proto_err)
);

// File: tb/test_merge_block_ctrl.sv
module test_merge_block_ctrl;
    import mgc_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [1:0]  req_blk = '0;
    logic [1:0]  req_word = '0;
    logic [1:0]  req_pe = '0;
    logic [63:0] req_data = '0;
    logic        busy, rsp_valid, rsp_flag, susp_valid, reinit_valid, proto_err;
    logic [1:0]  rsp_pe, susp_pe, susp_blk, reinit_blk;
    logic [63:0] rsp_data;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    merge_block_ctrl i_merge_block_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_blk(req_blk), .req_word(req_word), .req_pe(req_pe), .req_data(req_data),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_flag(rsp_flag), .rsp_pe(rsp_pe),
        .rsp_data(rsp_data), .susp_valid(susp_valid), .susp_pe(susp_pe),
        .susp_blk(susp_blk), .reinit_valid(reinit_valid), .reinit_blk(reinit_blk),
        .proto_err(proto_err)
    );

    typedef struct packed {
        mg_op_e      op;
        logic [1:0]  blk;
        logic [1:0]  word;
        logic [1:0]  pe;
        logic [63:0] data;
        logic        e_rsp;
        logic        e_flag;
        logic        e_susp;
        logic        e_reinit;
        logic        e_err;
        logic [63:0] e_data;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VEC [NV] = '{
        '{OP_BRD,   2'd0, 2'd2, 2'd0, 64'h0, 1, 0, 0, 0, 0, 64'h0, 8'd1},                     // R1 memory zero
        '{OP_BWR,   2'd0, 2'd1, 2'd0, 64'h1111, 0, 0, 0, 0, 0, 64'h0, 8'd8},                  // R8 write
        '{OP_BRD,   2'd0, 2'd1, 2'd0, 64'h0, 1, 0, 0, 0, 0, 64'h1111, 8'd8},                  // R8 read back
        '{OP_FETCH, 2'd0, 2'd0, 2'd0, 64'h0, 1, 0, 0, 0, 0, 64'h0000_0000_1111_0000, 8'd2},   // R2
        '{OP_FETCH, 2'd0, 2'd0, 2'd1, 64'h0, 1, 0, 0, 0, 0, 64'h0000_0000_1111_0000, 8'd2},   // R2 count 2
        '{OP_FLUSH, 2'd0, 2'd0, 2'd0, 64'h0000_2222_1111_AAAA, 0, 0, 0, 0, 0, 64'h0, 8'd5},   // R5 first merge
        '{OP_FETCH, 2'd0, 2'd0, 2'd2, 64'h0, 0, 0, 1, 0, 0, 64'h0, 8'd3},                     // R3 suspended
        '{OP_FLUSH, 2'd0, 2'd0, 2'd1, 64'h3333_5555_7777_0000, 0, 0, 0, 1, 0, 64'h0, 8'd7},   // R7 count hits 0
        '{OP_FETCH, 2'd0, 2'd0, 2'd2, 64'h0, 1, 0, 0, 0, 0, 64'h3333_2222_7777_AAAA, 8'd5},   // R5 merged line
        '{OP_FLUSH, 2'd0, 2'd0, 2'd2, 64'h0123_4567_89AB_CDEF, 0, 0, 0, 1, 0, 64'h0, 8'd4},   // R4 full write
        '{OP_BRD,   2'd0, 2'd3, 2'd0, 64'h0, 1, 0, 0, 0, 0, 64'h0123, 8'd4},                  // R4 read back
        '{OP_DROP,  2'd0, 2'd0, 2'd0, 64'h0, 0, 0, 0, 0, 1, 64'h0, 8'd12},                    // R12 drop at 0
        '{OP_FLUSH, 2'd0, 2'd0, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 0, 1, 64'h0, 8'd12},  // R12 flush at 0
        '{OP_BRD,   2'd0, 2'd0, 2'd0, 64'h0, 1, 0, 0, 0, 0, 64'hCDEF, 8'd12},                  // R12 memory kept
        '{OP_TAS,   2'd1, 2'd0, 2'd0, 64'h0, 1, 0, 0, 0, 0, 64'h0, 8'd9},                     // R9 was clear
        '{OP_TAS,   2'd1, 2'd0, 2'd1, 64'h0, 1, 1, 0, 0, 0, 64'h0, 8'd9},                     // R9 was set
        '{OP_LOCK,  2'd1, 2'd0, 2'd3, 64'h0, 0, 0, 1, 0, 0, 64'h0, 8'd10},                    // R10 held
        '{OP_UNLOCK,2'd1, 2'd0, 2'd0, 64'h0, 0, 0, 0, 1, 0, 64'h0, 8'd11},                    // R11
        '{OP_LOCK,  2'd1, 2'd0, 2'd3, 64'h0, 1, 0, 0, 0, 0, 64'h0, 8'd10},                    // R10 granted
        '{OP_FETCH, 2'd1, 2'd0, 2'd2, 64'h0, 0, 0, 1, 0, 0, 64'h0, 8'd3},                     // R3 locked block
        '{OP_UNLOCK,2'd1, 2'd0, 2'd0, 64'h0, 0, 0, 0, 1, 0, 64'h0, 8'd11},                    // R11
        '{OP_FETCH, 2'd1, 2'd0, 2'd2, 64'h0, 1, 0, 0, 0, 0, 64'h0, 8'd2},                     // R2 after unlock
        '{OP_FETCH, 2'd2, 2'd0, 2'd0, 64'h0, 1, 0, 0, 0, 0, 64'h0, 8'd2},                     // R2
        '{OP_FETCH, 2'd2, 2'd0, 2'd1, 64'h0, 1, 0, 0, 0, 0, 64'h0, 8'd2},                     // R2
        '{OP_DROP,  2'd2, 2'd0, 2'd0, 64'h0, 0, 0, 0, 0, 0, 64'h0, 8'd6},                     // R6 count 1
        '{OP_DROP,  2'd2, 2'd0, 2'd1, 64'h0, 0, 0, 0, 1, 0, 64'h0, 8'd6},                     // R6 count 0
        '{OP_FETCH, 2'd3, 2'd0, 2'd0, 64'h0, 1, 0, 0, 0, 0, 64'h0, 8'd2},                     // R2
        '{OP_FETCH, 2'd3, 2'd0, 2'd1, 64'h0, 1, 0, 0, 0, 0, 64'h0, 8'd2},                     // R2
        '{OP_FLUSH, 2'd3, 2'd0, 2'd0, 64'h0, 0, 0, 0, 0, 0, 64'h0, 8'd5},                     // R5 unchanged line
        '{OP_FETCH, 2'd3, 2'd0, 2'd2, 64'h0, 0, 0, 1, 0, 0, 64'h0, 8'd3},                     // R3
        '{OP_FLUSH, 2'd3, 2'd0, 2'd1, 64'h4444_3333_2222_1111, 0, 0, 0, 1, 0, 64'h0, 8'd5},   // R5 mask empty
        '{OP_FETCH, 2'd3, 2'd0, 2'd2, 64'h0, 1, 0, 0, 0, 0, 64'h4444_3333_2222_1111, 8'd5}    // R5 all words
    };

    task automatic chk(input bit ok, input int rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic issue(input mg_op_e op, input logic [1:0] blk, input logic [1:0] word,
                         input logic [1:0] pe, input logic [63:0] data);
        @(negedge clk);
        req_op = op; req_blk = blk; req_word = word; req_pe = pe; req_data = data;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state at the ports
        chk(!busy && !rsp_valid && !susp_valid && !reinit_valid && !proto_err, 1,
            "idle after reset", {busy, rsp_valid, susp_valid, reinit_valid, proto_err}, 0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VEC[i];
            issue(v.op, v.blk, v.word, v.pe, v.data);
            chk(rsp_valid == v.e_rsp, v.rq, $sformatf("vec %0d rsp_valid", i), rsp_valid, v.e_rsp);
            chk(susp_valid == v.e_susp, v.rq, $sformatf("vec %0d susp_valid", i), susp_valid, v.e_susp);
            chk(reinit_valid == v.e_reinit, v.rq, $sformatf("vec %0d reinit_valid", i), reinit_valid, v.e_reinit);
            chk(proto_err == v.e_err, v.rq, $sformatf("vec %0d proto_err", i), proto_err, v.e_err);
            if (v.e_rsp) begin
                chk(rsp_data == v.e_data, v.rq, $sformatf("vec %0d rsp_data", i), rsp_data, v.e_data);
                chk(rsp_flag == v.e_flag, v.rq, $sformatf("vec %0d rsp_flag", i), rsp_flag, v.e_flag);
                chk(rsp_pe == v.pe, v.rq, $sformatf("vec %0d rsp_pe", i), rsp_pe, v.pe);
            end
            if (v.e_susp) begin
                chk(susp_pe == v.pe && susp_blk == v.blk, v.rq, $sformatf("vec %0d susp id", i),
                    {susp_pe, susp_blk}, {v.pe, v.blk});
            end
            if (v.e_reinit)
                chk(reinit_blk == v.blk, v.rq, $sformatf("vec %0d reinit_blk", i), reinit_blk, v.blk);
        end

        // R5 / R13: merge length and requests ignored while busy
        issue(OP_FETCH, 2'd2, 2'd0, 2'd0, 64'h0);
        issue(OP_FETCH, 2'd2, 2'd0, 2'd1, 64'h0);
        begin
            int busy_cycles;
            busy_cycles = 0;
            @(negedge clk);
            req_op = OP_FLUSH; req_blk = 2'd2; req_pe = 2'd0;
            req_data = 64'h0D0C_0B0A_0908_0706; req_valid = 1'b1;
            @(negedge clk);
            req_op = OP_BWR; req_word = 2'd0; req_data = 64'hFFFF; // arrives while busy
            while (busy) begin
                busy_cycles++;
                @(negedge clk);
                req_valid = 1'b0;
            end
            req_valid = 1'b0;
            chk(busy_cycles == 4, 5, "merge busy cycles", busy_cycles, 4);
            chk(!reinit_valid, 5, "merge leaves holder", reinit_valid, 0);
        end
        issue(OP_BRD, 2'd2, 2'd0, 2'd0, 64'h0);
        chk(rsp_data == 64'h0706, 13, "write during busy ignored", rsp_data, 64'h0706);
        issue(OP_BRD, 2'd2, 2'd3, 2'd0, 64'h0);
        chk(rsp_data == 64'h0D0C, 5, "merged top word", rsp_data, 64'h0D0C);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule